// File: doc/BRIEF.md
# Hardware Loop Index Engine

This block holds the counting state for a small group of loops that run under hardware control. Each loop slot stores a start value, an upper bound, a step and a running index. Before a loop nest is entered, software fills these fields through a single write port, so no per-loop setup work remains inside the nest. The bound and the step can also be rewritten while the nest runs, which allows loops whose limits become known only during execution.

A task sequencer reports each task that completes. A completed task carries a loop number and a flag that says whether it closes a loop (backward) or not (forward). Only a backward completion moves the index of its loop. In the same cycle the engine raises a loop-end flag combinationally when that loop has run out of iterations, and the sequencer uses this flag to choose the next task. When a loop ends, its index returns to the start value, so the next entry into the loop begins fresh. Loop number 0 stands for the code outside the nest and has no state.

A second select input picks one loop whose current index drives a read-out port for the datapath.

Top module: `loop_index_engine`

## Requirements
- R1: While reset is applied and after it is released, every loop index reads 0, and `loop_end` stays low while no task is reported.
- R2: A write with field code 0 (start value) to loop n loads both the start value and the current index of loop n; the index reads the new value one cycle later.
- R3: A backward completion on loop n that does not end the loop adds the loop's step to its index; the new index is visible one cycle later.
- R4: `loop_end` is high in the same cycle as a backward completion on loop n exactly when index + step, computed without overflow (17 bits for 16-bit values), is greater than the bound of loop n; otherwise it is low.
- R5: A backward completion that raises `loop_end` reloads the index of that loop with its start value one cycle later.
- R6: A forward completion (`task_is_bwd` = 0) changes no index and never raises `loop_end`.
- R7: Loop 0 is reserved: writes to it are ignored, its index always reads 0 and it never raises `loop_end`.
- R8: A rewrite of the bound (field code 1) or the step (field code 2) takes effect on the very next termination test and index update of that loop.
- R9: When a write and a backward completion target the same loop in the same cycle, the write is applied and the index does not step; `loop_end` for that cycle is computed from the values held before the write.
- R10: A backward completion on one loop leaves the index of every other loop unchanged.
- R11: A write with field code 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Parameter write strobe |
| wr_loop | input | 3 | Loop number written |
| wr_field | input | 2 | Field code: 0 start value, 1 bound, 2 step, 3 none |
| wr_data | input | 16 | Value written |
| task_valid | input | 1 | A task completes this cycle |
| task_is_bwd | input | 1 | The completing task closes a loop |
| task_loop | input | 3 | Loop number of the completing task |
| idx_sel | input | 3 | Loop whose index is read out |
| idx_value | output | 16 | Current index of the selected loop |
| loop_end | output | 1 | The reported backward task ends its loop |

## Verification
The assertions watch, on every cycle, the relations visible at the ports: that `loop_end` only accompanies a backward completion on a real loop, that loop 0 stays at zero, that forward completions and completions on other loops leave the selected index still, that a start-value write lands in the index and that a colliding write freezes the step. The arithmetic itself (the step added, the reload on exhaustion, the carry-aware bound test and the effect of a bound or step rewritten mid-run) needs known parameter values, so only the bench's scripted sequences can show it.

// File: rtl/loop_idx_pkg.sv
package loop_idx_pkg;
  typedef enum logic [1:0] {
    FLD_START  = 2'd0,
    FLD_BOUND  = 2'd1,
    FLD_STEP   = 2'd2,
    FLD_UNUSED = 2'd3
  } field_e;
endpackage

// File: rtl/loop_idx_term.sv
module loop_idx_term #(
  parameter int IDX_W = 16
) (
  input  logic [IDX_W-1:0] cur_idx,
  input  logic [IDX_W-1:0] step,
  input  logic [IDX_W-1:0] bound,
  output logic             exhausted
);
  logic [IDX_W:0] next_sum;

  always_comb begin
    next_sum  = {1'b0, cur_idx} + {1'b0, step};
    exhausted = (next_sum > {1'b0, bound});
  end
endmodule

// File: rtl/loop_idx_slot.sv
module loop_idx_slot
  import loop_idx_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [1:0]       wr_field,
  input  logic [IDX_W-1:0] wr_data,
  input  logic             step_hit,
  output logic [IDX_W-1:0] idx_o,
  output logic             exhausted_o
);
  logic [IDX_W-1:0] start_q, bound_q, step_q, idx_q;
  logic [IDX_W-1:0] start_n, bound_n, step_n, idx_n;
  logic             reg_en;
  logic             done_now;

  loop_idx_term #(.IDX_W(IDX_W)) u_term (
    .cur_idx  (idx_q),
    .step     (step_q),
    .bound    (bound_q),
    .exhausted(done_now)
  );

  always_comb begin
    start_n = start_q;
    bound_n = bound_q;
    step_n  = step_q;
    idx_n   = idx_q;
    if (wr_hit) begin
      case (field_e'(wr_field))
        FLD_START: begin
          start_n = wr_data;
          idx_n   = wr_data;
        end
        FLD_BOUND: bound_n = wr_data;
        FLD_STEP:  step_n  = wr_data;
        default:   ;
      endcase
    end else if (step_hit) begin
      idx_n = done_now ? start_q : idx_q + step_q;
    end
  end

  assign reg_en = wr_hit | step_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      bound_q <= '0;
      step_q  <= {{(IDX_W-1){1'b0}}, 1'b1};
      idx_q   <= '0;
    end else if (reg_en) begin
      start_q <= start_n;
      bound_q <= bound_n;
      step_q  <= step_n;
      idx_q   <= idx_n;
    end
  end

  assign idx_o       = idx_q;
  assign exhausted_o = done_now;
endmodule

// File: rtl/loop_index_engine.sv
module loop_index_engine #(
  parameter int NUM_LOOPS = 8,
  parameter int IDX_W     = 16,
  localparam int SEL_W    = $clog2(NUM_LOOPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_loop,
  input  logic [1:0]       wr_field,
  input  logic [IDX_W-1:0] wr_data,
  input  logic             task_valid,
  input  logic             task_is_bwd,
  input  logic [SEL_W-1:0] task_loop,
  input  logic [SEL_W-1:0] idx_sel,
  output logic [IDX_W-1:0] idx_value,
  output logic             loop_end
);
  logic             rst_meta_n, rst_q_n;
  logic [IDX_W-1:0] idx_a [NUM_LOOPS];
  logic             exh_a [NUM_LOOPS];
  logic             bwd_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  assign bwd_now = task_valid & task_is_bwd;

  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
    if (g == 0) begin : g_reserved
      assign idx_a[g] = '0;
      assign exh_a[g] = 1'b0;
    end else begin : g_slot
      logic wr_hit_g, step_hit_g;
      assign wr_hit_g   = wr_en & (wr_loop == SEL_W'(g));
      assign step_hit_g = bwd_now & (task_loop == SEL_W'(g)) & ~wr_hit_g;
      loop_idx_slot #(.IDX_W(IDX_W)) u_slot (
        .clk        (clk),
        .rst_n      (rst_q_n),
        .wr_hit     (wr_hit_g),
        .wr_field   (wr_field),
        .wr_data    (wr_data),
        .step_hit   (step_hit_g),
        .idx_o      (idx_a[g]),
        .exhausted_o(exh_a[g])
      );
    end
  end

  assign loop_end  = bwd_now & exh_a[task_loop];
  assign idx_value = idx_a[idx_sel];
endmodule

// File: rtl/loop_index_engine_chk.sv
module loop_index_engine_chk #(
  parameter int SEL_W = 3,
  parameter int IDX_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [SEL_W-1:0] wr_loop,
  input logic [1:0]       wr_field,
  input logic [IDX_W-1:0] wr_data,
  input logic             task_valid,
  input logic             task_is_bwd,
  input logic [SEL_W-1:0] task_loop,
  input logic [SEL_W-1:0] idx_sel,
  input logic [IDX_W-1:0] idx_value,
  input logic             loop_end
);
  a_r4_end_needs_bwd: assert property (@(posedge clk) disable iff (!rst_n)
    loop_end |-> (task_valid && task_is_bwd));

  a_r6_fwd_no_end: assert property (@(posedge clk) disable iff (!rst_n)
    (task_valid && !task_is_bwd) |-> !loop_end);

  a_r6_fwd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (task_valid && !task_is_bwd && !wr_en) |=>
      (idx_sel != $past(idx_sel)) || $stable(idx_value));

  a_r7_loop0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_sel == '0) |-> (idx_value == '0));

  a_r7_loop0_no_end: assert property (@(posedge clk) disable iff (!rst_n)
    (task_loop == '0) |-> !loop_end);

  a_r2_start_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_loop != '0 && wr_field == 2'd0) |=>
      (idx_sel != $past(wr_loop)) || (idx_value == $past(wr_data)));

  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && task_valid && task_is_bwd && wr_loop == task_loop &&
     idx_sel == wr_loop && wr_field != 2'd0) |=>
      (idx_sel != $past(idx_sel)) || $stable(idx_value));

  a_r10_other_loop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (task_valid && task_is_bwd && task_loop != idx_sel &&
     !(wr_en && wr_loop == idx_sel)) |=>
      (idx_sel != $past(idx_sel)) || $stable(idx_value));
endmodule

bind loop_index_engine loop_index_engine_chk #(.SEL_W(SEL_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .wr_en      (wr_en),
  .wr_loop    (wr_loop),
  .wr_field   (wr_field),
  .wr_data    (wr_data),
  .task_valid (task_valid),
  .task_is_bwd(task_is_bwd),
  .task_loop  (task_loop),
  .idx_sel    (idx_sel),
  .idx_value  (idx_value),
  .loop_end   (loop_end)
);

// File: tb/loop_index_engine_bench.sv
module loop_index_engine_bench;
  localparam int NV = 21;
  // {req[4], we, wloop[3], field[2], data[16], tv, bwd, tloop[3], sel[3], exp_end, exp_idx[16]}
  localparam logic [50:0] VEC [NV] = '{
    {4'd2,  1'b1,3'd1,2'd0,16'd5,     1'b0,1'b0,3'd0, 3'd1,1'b0,16'd5},     // R2 start
    {4'd2,  1'b1,3'd1,2'd1,16'd11,    1'b0,1'b0,3'd0, 3'd1,1'b0,16'd5},     // bound
    {4'd2,  1'b1,3'd1,2'd2,16'd3,     1'b0,1'b0,3'd0, 3'd1,1'b0,16'd5},     // step
    {4'd3,  1'b0,3'd0,2'd0,16'd0,     1'b1,1'b1,3'd1, 3'd1,1'b0,16'd8},     // R3
    {4'd6,  1'b0,3'd0,2'd0,16'd0,     1'b1,1'b0,3'd1, 3'd1,1'b0,16'd8},     // R6 forward
    {4'd3,  1'b0,3'd0,2'd0,16'd0,     1'b1,1'b1,3'd1, 3'd1,1'b0,16'd11},    // R3 equal bound
    {4'd5,  1'b0,3'd0,2'd0,16'd0,     1'b1,1'b1,3'd1, 3'd1,1'b1,16'd5},     // R4 R5 reload
    {4'd8,  1'b1,3'd1,2'd1,16'd20,    1'b0,1'b0,3'd0, 3'd1,1'b0,16'd5},     // R8 bound rewrite
    {4'd3,  1'b0,3'd0,2'd0,16'd0,     1'b1,1'b1,3'd1, 3'd1,1'b0,16'd8},
    {4'd9,  1'b1,3'd1,2'd2,16'd13,    1'b1,1'b1,3'd1, 3'd1,1'b0,16'd8},     // R9 collision
    {4'd8,  1'b0,3'd0,2'd0,16'd0,     1'b1,1'b1,3'd1, 3'd1,1'b1,16'd5},     // R8 new step ends
    {4'd7,  1'b1,3'd0,2'd0,16'd9,     1'b0,1'b0,3'd0, 3'd0,1'b0,16'd0},     // R7 write ignored
    {4'd7,  1'b0,3'd0,2'd0,16'd0,     1'b1,1'b1,3'd0, 3'd0,1'b0,16'd0},     // R7 no end
    {4'd2,  1'b1,3'd2,2'd0,16'd100,   1'b0,1'b0,3'd0, 3'd2,1'b0,16'd100},
    {4'd2,  1'b1,3'd2,2'd1,16'hFFF0,  1'b0,1'b0,3'd0, 3'd2,1'b0,16'd100},
    {4'd2,  1'b1,3'd2,2'd2,16'h8000,  1'b0,1'b0,3'd0, 3'd2,1'b0,16'd100},
    {4'd3,  1'b0,3'd0,2'd0,16'd0,     1'b1,1'b1,3'd2, 3'd2,1'b0,16'd32868},
    {4'd4,  1'b0,3'd0,2'd0,16'd0,     1'b1,1'b1,3'd2, 3'd2,1'b1,16'd100},   // R4 carry case
    {4'd10, 1'b0,3'd0,2'd0,16'd0,     1'b1,1'b1,3'd1, 3'd2,1'b0,16'd100},   // R10
    {4'd11, 1'b1,3'd2,2'd3,16'd7,     1'b0,1'b0,3'd0, 3'd2,1'b0,16'd100},   // R11
    {4'd9,  1'b1,3'd2,2'd0,16'd40,    1'b1,1'b1,3'd2, 3'd2,1'b0,16'd40}     // R9 start wins
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, task_valid, task_is_bwd;
  logic [2:0]  wr_loop, task_loop, idx_sel;
  logic [1:0]  wr_field;
  logic [15:0] wr_data, idx_value;
  logic        loop_end;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  loop_index_engine u_loop_index_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_loop(wr_loop),
    .wr_field(wr_field), .wr_data(wr_data), .task_valid(task_valid),
    .task_is_bwd(task_is_bwd), .task_loop(task_loop), .idx_sel(idx_sel),
    .idx_value(idx_value), .loop_end(loop_end)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0; wr_loop = '0; wr_field = '0; wr_data = '0;
    task_valid = 1'b0; task_is_bwd = 1'b0; task_loop = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog R1..: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; idle(); idx_sel = '0;
    do_reset();
    // R1: reset state of every loop
    for (int s = 0; s < 8; s++) begin
      idx_sel = 3'(s); #1;
      chk("R1 idx after reset", 32'(idx_value), 32'd0);
    end
    chk("R1 loop_end idle", 32'(loop_end), 32'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_en       = VEC[i][46];
      wr_loop     = VEC[i][45:43];
      wr_field    = VEC[i][42:41];
      wr_data     = VEC[i][40:25];
      task_valid  = VEC[i][24];
      task_is_bwd = VEC[i][23];
      task_loop   = VEC[i][22:20];
      idx_sel     = VEC[i][19:17];
      #1;
      chk($sformatf("R%0d end vec%0d", VEC[i][50:47], i), 32'(loop_end), 32'(VEC[i][16]));
      @(posedge clk); #1;
      chk($sformatf("R%0d idx vec%0d", VEC[i][50:47], i), 32'(idx_value), 32'(VEC[i][15:0]));
    end

    // R10: loop 1 stepped by vector 19 (5 + 13 = 18)
    @(negedge clk); idle(); idx_sel = 3'd1; #1;
    chk("R10 loop1 after own step", 32'(idx_value), 32'd18);

    // R1: reset mid-run clears indices
    do_reset();
    idx_sel = 3'd1; #1;
    chk("R1 loop1 after reset", 32'(idx_value), 32'd0);
    idx_sel = 3'd2; #1;
    chk("R1 loop2 after reset", 32'(idx_value), 32'd0);
    chk("R1 loop_end after reset", 32'(loop_end), 32'd0);

    finish_run();
  end
endmodule